// File: doc/BRIEF.md
# Read-Modify-Write Dead-Cycle Controller

This block sits between the microcode sequencer of a 6502-compatible core and its external bus. It takes over the bus during the three bus cycles of a read-modify-write instruction: a read of the target, a modify cycle in which the ALU works, and a write of the result back to the same target. The microcode flags such a sequence with a single operation. This block then produces the bus behaviour of the modify cycle on its own, according to a CPU-variant select. In NMOS mode the modify cycle writes the unmodified operand back to the target. In CMOS mode the modify cycle repeats the read. An active-low lock pin is held low for all three cycles so that external arbiters cannot split the sequence.

The block also handles the dead cycle of zero-page indexed addressing. While the ALU adds the index, the bus reads from the unindexed zero-page base address, and the block flags the returned byte for discarding. Outside these cycles, the core's address, direction and write data pass straight through. A `step` strobe marks the end of each bus cycle, so a cycle that is held off by wait states simply persists.

The controller is a five-state machine:

- IDLE: passthrough.
- READ: the first RMW cycle.
- MODIFY: the dead cycle.
- WRITE: the final RMW cycle.
- INDEX: the zero-page indexed dead read.

Each transition is taken only on `step`:

- Start RMW: IDLE→READ, on `rmw_start`.
- Start index: IDLE→INDEX, on `zpx_start` without `rmw_start`.
- Read done: READ→MODIFY. The read byte is captured here.
- Modify done: MODIFY→WRITE.
- Write done: WRITE→IDLE.
- Index done: INDEX→IDLE.

Top module: `rmw_dead_cycle_ctrl`

## Requirements
- R1: Reset, at any time, puts the block in IDLE. `lock_n` is 1, `rd_discard` is 0, and the outputs pass the core signals through.
- R2: `rmw_start` with `step` in IDLE makes the next bus cycle a read (`bus_rw_n`=1) of the address on `core_addr` at that edge.
- R3: `lock_n` is 0 in the READ, MODIFY and WRITE cycles and returns to 1 in the cycle after the WRITE cycle completes.
- R4: `bus_addr` stays at the captured target address through all three RMW cycles, whatever `core_addr` does.
- R5: With `cmos_sel`=0 (NMOS), the MODIFY cycle is a write: `bus_rw_n`=0, `wdata_sel`=1, and `bus_wdata` is the byte on `rd_data` when the READ cycle completed.
- R6: With `cmos_sel`=1 (CMOS), the MODIFY cycle is a read: `bus_rw_n`=1 and `wdata_sel`=0.
- R7: The WRITE cycle drives `bus_rw_n`=0, with `bus_wdata` equal to `core_wdata` and `wdata_sel`=0.
- R8: While `step` is 0, the current bus cycle and its outputs persist.
- R9: The variant is sampled at the start of the sequence. A change of `cmos_sel` during the sequence has no effect on that sequence.
- R10: `rmw_start` asserted while a sequence is active is ignored. The sequence still ends after WRITE, with `lock_n` back to 1.
- R11: `zpx_start` with `step` in IDLE gives one INDEX cycle. In that cycle `bus_rw_n`=1, `bus_addr` has zero upper bits and the base's low 8 bits, `rd_discard`=1 and `lock_n`=1. The block then returns to IDLE.
- R12: If `rmw_start` and `zpx_start` arrive together, the RMW sequence wins.
- R13: In IDLE, `bus_addr`, `bus_rw_n` and `bus_wdata` equal `core_addr`, `core_rw_n` and `core_wdata`, and `wdata_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | End of the current bus cycle |
| rmw_start | input | 1 | Microcode flag that starts a read-modify-write sequence |
| zpx_start | input | 1 | Microcode flag that starts a zero-page indexed dead read |
| cmos_sel | input | 1 | Variant select: 0 NMOS, 1 CMOS |
| core_addr | input | AW (16) | Address from the core datapath |
| core_rw_n | input | 1 | Core direction: 1 read, 0 write |
| core_wdata | input | DW (8) | Core write data, including the modified result |
| rd_data | input | DW (8) | Read data from the bus |
| bus_addr | output | AW (16) | Address driven to the bus |
| bus_rw_n | output | 1 | Bus direction after the override |
| bus_wdata | output | DW (8) | Data driven to the bus |
| wdata_sel | output | 1 | 1 when the bus data is the captured operand |
| lock_n | output | 1 | Active-low memory lock |
| rd_discard | output | 1 | Read data in this cycle must be discarded |

## Verification
RMW sequences are swept over both variants, several target addresses and several operand bytes. Each sequence is run both with and without a wait state in the read cycle. The address is scrambled and the variant select is flipped mid-sequence, which separates a latched target and variant from a passthrough. The captured operand is changed after capture, which separates a byte taken at the end of the read from a live `rd_data` path. Index dead reads use bases with nonzero high bytes to show that the upper address bits are forced to zero. Simultaneous start flags and repeated start flags probe the priority and the ignore rules, and a reset in the middle of a sequence shows that the lock is released.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_MODIFY = 3'd2,
        ST_WRITE  = 3'd3,
        ST_INDEX  = 3'd4
    } rmw_state_t;
endpackage

// File: rtl/rmw_fsm.sv
module rmw_fsm
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       rmw_start,
    input  logic       zpx_start,
    output rmw_state_t state
);
    rmw_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (step) begin
            unique case (state)
                ST_IDLE: begin
                    if (rmw_start)      state_nx = ST_READ;
                    else if (zpx_start) state_nx = ST_INDEX;
                end
                ST_READ:   state_nx = ST_MODIFY;
                ST_MODIFY: state_nx = ST_WRITE;
                ST_WRITE:  state_nx = ST_IDLE;
                ST_INDEX:  state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // R10: an in-flight sequence never restarts at READ
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_READ, ST_MODIFY} && step) |=> state != ST_READ);

    // R8: without step the state is held
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));
endmodule

// File: rtl/rmw_capture.sv
module rmw_capture
    import rmw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int ZPW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  rmw_state_t    state,
    input  logic          rmw_start,
    input  logic          zpx_start,
    input  logic          cmos_sel,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] hold_addr,
    output logic          hold_cmos,
    output logic [DW-1:0] hold_data
);
    localparam int HIW = AW - ZPW;

    logic idle_step;
    assign idle_step = (state == ST_IDLE) && step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_cmos <= 1'b0;
            hold_data <= '0;
        end else begin
            if (idle_step && rmw_start) begin
                hold_addr <= core_addr;
                hold_cmos <= cmos_sel;
            end else if (idle_step && zpx_start) begin
                hold_addr <= {{HIW{1'b0}}, core_addr[ZPW-1:0]};
            end
            if (state == ST_READ && step)
                hold_data <= rd_data;
        end
    end

    // R9: the variant does not change within a sequence
    p_variant_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_MODIFY, ST_WRITE}) |-> $stable(hold_cmos));
endmodule

// File: rtl/rmw_busmux.sv
module rmw_busmux
    import rmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  rmw_state_t    state,
    input  logic          hold_cmos,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_data,
    input  logic [AW-1:0] core_addr,
    input  logic          core_rw_n,
    input  logic [DW-1:0] core_wdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw_n,
    output logic [DW-1:0] bus_wdata,
    output logic          wdata_sel,
    output logic          lock_n,
    output logic          rd_discard
);
    always_comb begin
        bus_addr   = core_addr;
        bus_rw_n   = core_rw_n;
        bus_wdata  = core_wdata;
        wdata_sel  = 1'b0;
        lock_n     = 1'b1;
        rd_discard = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_READ: begin
                bus_addr = hold_addr;
                bus_rw_n = 1'b1;
                lock_n   = 1'b0;
            end
            ST_MODIFY: begin
                bus_addr = hold_addr;
                lock_n   = 1'b0;
                if (hold_cmos) begin
                    bus_rw_n = 1'b1;
                end else begin
                    bus_rw_n  = 1'b0;
                    bus_wdata = hold_data;
                    wdata_sel = 1'b1;
                end
            end
            ST_WRITE: begin
                bus_addr = hold_addr;
                bus_rw_n = 1'b0;
                lock_n   = 1'b0;
            end
            ST_INDEX: begin
                bus_addr   = hold_addr;
                bus_rw_n   = 1'b1;
                rd_discard = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_dead_cycle_ctrl.sv
module rmw_dead_cycle_ctrl
    import rmw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int ZPW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          rmw_start,
    input  logic          zpx_start,
    input  logic          cmos_sel,
    input  logic [AW-1:0] core_addr,
    input  logic          core_rw_n,
    input  logic [DW-1:0] core_wdata,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw_n,
    output logic [DW-1:0] bus_wdata,
    output logic          wdata_sel,
    output logic          lock_n,
    output logic          rd_discard
);
    localparam int HIW = AW - ZPW;

    rmw_state_t    state;
    logic [AW-1:0] hold_addr;
    logic          hold_cmos;
    logic [DW-1:0] hold_data;

    rmw_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .rmw_start (rmw_start),
        .zpx_start (zpx_start),
        .state     (state)
    );

    rmw_capture #(.AW(AW), .DW(DW), .ZPW(ZPW)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .state     (state),
        .rmw_start (rmw_start),
        .zpx_start (zpx_start),
        .cmos_sel  (cmos_sel),
        .core_addr (core_addr),
        .rd_data   (rd_data),
        .hold_addr (hold_addr),
        .hold_cmos (hold_cmos),
        .hold_data (hold_data)
    );

    rmw_busmux #(.AW(AW), .DW(DW)) i_busmux (
        .state      (state),
        .hold_cmos  (hold_cmos),
        .hold_addr  (hold_addr),
        .hold_data  (hold_data),
        .core_addr  (core_addr),
        .core_rw_n  (core_rw_n),
        .core_wdata (core_wdata),
        .bus_addr   (bus_addr),
        .bus_rw_n   (bus_rw_n),
        .bus_wdata  (bus_wdata),
        .wdata_sel  (wdata_sel),
        .lock_n     (lock_n),
        .rd_discard (rd_discard)
    );

    // R2 / R3: an accepted start makes the next cycle a locked read
    p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && step && rmw_start) |=> (!lock_n && bus_rw_n));

    // R3: the lock is released after the write completes
    p_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && step) |=> lock_n);

    // R4: the address is constant in the later RMW cycles
    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_MODIFY, ST_WRITE}) |-> bus_addr == $past(bus_addr));

    // R5: the NMOS dead write returns the byte just read
    p_nmos_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_READ && state == ST_MODIFY && !bus_rw_n)
        |-> bus_wdata == $past(rd_data));

    // R11: the index dead read is a discarded zero-page read
    p_zp_dead_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_discard |-> (bus_rw_n && lock_n && bus_addr[AW-1:ZPW] == {HIW{1'b0}}));

    // R1: reset leaves the lock released
    p_reset_unlock_r1: assert property (@(posedge clk) !rst_n |=> lock_n);
endmodule

// File: tb/test_rmw_dead_cycle_ctrl.sv
module test_rmw_dead_cycle_ctrl;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0;
    logic          rmw_start = 1'b0;
    logic          zpx_start = 1'b0;
    logic          cmos_sel = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          core_rw_n = 1'b1;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] rd_data = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_rw_n;
    logic [DW-1:0] bus_wdata;
    logic          wdata_sel;
    logic          lock_n;
    logic          rd_discard;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rmw_dead_cycle_ctrl #(.AW(AW), .DW(DW), .ZPW(8)) i_rmw_dead_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .step(step), .rmw_start(rmw_start),
        .zpx_start(zpx_start), .cmos_sel(cmos_sel), .core_addr(core_addr),
        .core_rw_n(core_rw_n), .core_wdata(core_wdata), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rw_n(bus_rw_n), .bus_wdata(bus_wdata),
        .wdata_sel(wdata_sel), .lock_n(lock_n), .rd_discard(rd_discard)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edge_then_drive;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        step = 1'b0; rmw_start = 1'b0; zpx_start = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [4];
        logic [DW-1:0] datas [4];
        addrs[0] = 16'h0000; addrs[1] = 16'h00A0; addrs[2] = 16'h12FF; addrs[3] = 16'hFFFE;
        datas[0] = 8'h00; datas[1] = 8'h81; datas[2] = 8'h7F; datas[3] = 8'hC3;

        // reset state
        core_addr = 16'h1234; core_rw_n = 1'b0; core_wdata = 8'h5A;
        #1;
        chk("R1 lock_n in reset", lock_n, 1);
        chk("R1 discard in reset", rd_discard, 0);
        chk("R1 addr passthrough in reset", bus_addr, 16'h1234);
        chk("R1 rw passthrough in reset", bus_rw_n, 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; core_rw_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 2; v++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int di = 0; di < 4; di++) begin
                    for (int st = 0; st < 2; st++) begin
                        logic [AW-1:0] a;
                        logic [DW-1:0] d, m;
                        a = addrs[ai] ^ AW'(di * 16'h0101);
                        d = datas[di] ^ DW'(ai);
                        m = DW'(d << 1);
                        // idle cycle with start request
                        core_addr = a; core_rw_n = 1'b1; core_wdata = 8'hEE;
                        cmos_sel = v[0]; rmw_start = 1'b1; step = 1'b1;
                        #1;
                        chk("R13 idle addr", bus_addr, a);
                        chk("R13 idle sel", wdata_sel, 0);
                        chk("R3 idle lock", lock_n, 1);
                        edge_then_drive();
                        // read cycle
                        core_addr = ~a; rd_data = d; cmos_sel = ~v[0];
                        rmw_start = 1'b1; step = (st == 0);
                        #1;
                        chk("R2 read dir", bus_rw_n, 1);
                        chk("R4 read addr", bus_addr, a);
                        chk("R3 read lock", lock_n, 0);
                        if (st == 1) begin
                            edge_then_drive();
                            step = 1'b1; rd_data = d;
                            #1;
                            chk("R8 stalled read dir", bus_rw_n, 1);
                            chk("R8 stalled read addr", bus_addr, a);
                            chk("R8 stalled lock", lock_n, 0);
                        end
                        edge_then_drive();
                        // modify cycle
                        rd_data = ~d; core_wdata = m; rmw_start = 1'b1; step = 1'b1;
                        #1;
                        chk("R4 modify addr", bus_addr, a);
                        chk("R3 modify lock", lock_n, 0);
                        if (v == 0) begin
                            chk("R5 R9 nmos modify dir", bus_rw_n, 0);
                            chk("R5 nmos modify data", bus_wdata, d);
                            chk("R5 nmos modify sel", wdata_sel, 1);
                        end else begin
                            chk("R6 R9 cmos modify dir", bus_rw_n, 1);
                            chk("R6 cmos modify sel", wdata_sel, 0);
                        end
                        edge_then_drive();
                        // write cycle
                        core_wdata = m; step = 1'b1; rmw_start = 1'b1;
                        #1;
                        chk("R7 write dir", bus_rw_n, 0);
                        chk("R7 write data", bus_wdata, m);
                        chk("R7 write sel", wdata_sel, 0);
                        chk("R4 write addr", bus_addr, a);
                        chk("R3 write lock", lock_n, 0);
                        edge_then_drive();
                        // back to idle
                        idle_inputs(); core_addr = a ^ 16'h0F0F; core_rw_n = 1'b0;
                        #1;
                        chk("R10 lock after ignored restarts", lock_n, 1);
                        chk("R13 idle addr after", bus_addr, a ^ 16'h0F0F);
                        chk("R13 idle dir after", bus_rw_n, 0);
                        edge_then_drive();
                    end
                end
            end
        end

        // zero-page indexed dead reads
        for (int ai = 0; ai < 4; ai++) begin
            logic [AW-1:0] a;
            a = addrs[ai] | 16'h3400;
            core_addr = a; core_rw_n = 1'b0; zpx_start = 1'b1; step = 1'b1;
            edge_then_drive();
            zpx_start = 1'b0; core_addr = 16'hBEEF;
            #1;
            chk("R11 index dir", bus_rw_n, 1);
            chk("R11 index addr", bus_addr, {8'h00, a[7:0]});
            chk("R11 index discard", rd_discard, 1);
            chk("R11 index lock", lock_n, 1);
            edge_then_drive();
            idle_inputs();
            #1;
            chk("R11 back to idle discard", rd_discard, 0);
            chk("R11 back to idle addr", bus_addr, 16'hBEEF);
            edge_then_drive();
        end

        // simultaneous starts
        core_addr = 16'h2040; core_rw_n = 1'b1; cmos_sel = 1'b0;
        rmw_start = 1'b1; zpx_start = 1'b1; step = 1'b1;
        edge_then_drive();
        rmw_start = 1'b0; zpx_start = 1'b0;
        #1;
        chk("R12 rmw wins lock", lock_n, 0);
        chk("R12 rmw wins discard", rd_discard, 0);
        chk("R12 rmw wins addr", bus_addr, 16'h2040);
        edge_then_drive();
        #1;
        chk("R12 modify follows", bus_rw_n, 0);

        // reset in the middle of a sequence
        rst_n = 1'b0;
        #1;
        chk("R1 mid-sequence reset lock", lock_n, 1);
        chk("R1 mid-sequence reset sel", wdata_sel, 0);
        idle_inputs();
        edge_then_drive();
        rst_n = 1'b1;
        edge_then_drive();
        #1;
        chk("R1 idle after reset", lock_n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule